// File: doc/BRIEF.md
# In-Order Commit Checker Stage

This stage sits behind the commit point of an out-of-order core. It checks every retiring instruction again, in program order, before its result becomes architectural. Each packet names an operation, two source registers, the operand values the core used, a destination register and the result the core claims. The checker holds its own architectural register file. It runs two checks on each packet. The storage check reads both sources from that file and compares them with the supplied operands. The ALU check recomputes the operation on the verified values and compares it with the claimed result.

A packet that passes both checks commits and writes its destination. A failing packet raises a sticky error that carries a cause and the packet's sequence number. The core is then restarted from that instruction. The checker's own register file is taken as correct. A retire watchdog flags a core that has stopped delivering packets.

The checker is a two-stage pipeline that never stalls. Stage one reads the register file, with forwarding from the write in flight. Stage two compares, commits and writes. Back-to-back dependent packets therefore verify at full rate.

Top module: `commit_checker`

## Requirements
- R1: Each accepted packet takes the next sequence number, counting from 0 after reset. `commit_seq_o` shows the number of the packet being committed.
- R2: A packet whose supplied operands differ from the register file values of its sources fails with cause 2'b01. This cause takes priority over a result failure.
- R3: The ALU check recomputes the operation and compares it with the claimed result. The opcodes are 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR and 5 SLT; SLT is a signed compare that yields 1 or 0. A mismatch, or opcode 6 or 7, fails with cause 2'b10.
- R4: A packet presented in cycle c is checked in cycle c+1. When it passes, `commit_o` is high in c+1 with its destination, data and sequence number, and the register file is updated at the end of that cycle. A failing packet writes nothing.
- R5: After reset, register k holds the value k. Register 0 always reads zero, and writes to it are discarded.
- R6: `err_o` rises in the cycle after a failing check and stays high, with its cause and `err_seq_o` held, until a restart. Packets are dropped while `err_o` is high. A packet that arrives in the same cycle as the failing check is also dropped.
- R7: `restart_i` while `err_o` is high clears the error on the next cycle. Numbering then resumes at the faulting packet's sequence number.
- R8: If no packet is accepted for TIMEOUT_CYC consecutive cycles while there is no error, the error is raised with cause 2'b11 and the next expected sequence number. Every accepted packet reloads the count.
- R9: A packet whose source is the destination of the packet directly ahead of it sees the forwarded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pkt_valid_i | input | 1 | Retire packet present |
| pkt_op_i | input | 3 | Operation code |
| pkt_rs1_i | input | 4 | First source index |
| pkt_rs2_i | input | 4 | Second source index |
| pkt_opa_i | input | 32 | First operand as used by the core |
| pkt_opb_i | input | 32 | Second operand as used by the core |
| pkt_rd_i | input | 4 | Destination index |
| pkt_res_i | input | 32 | Claimed result |
| restart_i | input | 1 | Restart acknowledge from the core |
| commit_o | output | 1 | Packet verified and committed |
| commit_rd_o | output | 4 | Committed destination |
| commit_data_o | output | 32 | Committed value |
| commit_seq_o | output | 8 | Committed sequence number |
| err_o | output | 1 | Sticky check error |
| err_cause_o | output | 2 | 01 operand, 10 result, 11 timeout |
| err_seq_o | output | 8 | Sequence number of the faulting packet |

## Verification
A wrong register file entry shows up as a false operand failure. It appears two cycles after the first packet that reads that entry with correct operands. A missing forward shows up the same way, but only on dependent back-to-back pairs. A drifting sequence counter shows on `commit_seq_o` at the next commit, and again in `err_seq_o` at replay. A miscounting watchdog shifts the cycle in which `err_o` rises with cause 11, and the per-cycle reference model flags that cycle directly.

// File: rtl/chk_pkg.sv
package chk_pkg;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;
  localparam logic [2:0] OP_SLT = 3'd5;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_OPND = 2'b01,
    CAUSE_RES  = 2'b10,
    CAUSE_TMO  = 2'b11
  } cause_e;
endpackage

// File: rtl/chk_alu.sv
module chk_alu #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              legal_o
);
  import chk_pkg::*;

  always_comb begin
    legal_o = 1'b1;
    res_o   = '0;
    case (op_i)
      OP_ADD: res_o = a_i + b_i;
      OP_SUB: res_o = a_i - b_i;
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_SLT: res_o = {{(DATA_W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/chk_regfile.sv
module chk_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  parameter int NRD    = 2,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             wa_i,
  input  logic [DATA_W-1:0]            wd_i,
  input  logic [NRD-1:0][IDX_W-1:0]    ra_i,
  output logic [NRD-1:0][DATA_W-1:0]   rd_o
);
  logic [DATA_W-1:0] mem [NREG];

  // reset image: entry k holds k
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem[i] <= DATA_W'(i);
    end else if (we_i && wa_i != '0) begin
      mem[wa_i] <= wd_i;
    end
  end

  // read ports forward the write of the stage ahead
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (ra_i[p] == '0)                        rd_o[p] = '0;
      else if (we_i && wa_i == ra_i[p])         rd_o[p] = wd_i;
      else                                      rd_o[p] = mem[ra_i[p]];
    end
  end
endmodule

// File: rtl/chk_watchdog.sv
module chk_watchdog #(
  parameter int LIMIT = 1024,
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic fire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign fire_o = !clr_i && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || fire_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assert_reload_blocks_fire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !fire_o);
endmodule

// File: rtl/commit_checker.sv
module commit_checker #(
  parameter int DATA_W      = 32,
  parameter int NREG        = 16,
  parameter int SEQ_W       = 8,
  parameter int TIMEOUT_CYC = 1024,
  localparam int IDX_W      = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_valid_i,
  input  logic [2:0]        pkt_op_i,
  input  logic [IDX_W-1:0]  pkt_rs1_i,
  input  logic [IDX_W-1:0]  pkt_rs2_i,
  input  logic [DATA_W-1:0] pkt_opa_i,
  input  logic [DATA_W-1:0] pkt_opb_i,
  input  logic [IDX_W-1:0]  pkt_rd_i,
  input  logic [DATA_W-1:0] pkt_res_i,
  input  logic              restart_i,
  output logic              commit_o,
  output logic [IDX_W-1:0]  commit_rd_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic [SEQ_W-1:0]  commit_seq_o,
  output logic              err_o,
  output logic [1:0]        err_cause_o,
  output logic [SEQ_W-1:0]  err_seq_o
);
  import chk_pkg::*;

  // stage B (check) registers
  logic              b_v;
  logic [2:0]        b_op;
  logic [DATA_W-1:0] b_opa, b_opb, b_ra, b_rb, b_res;
  logic [IDX_W-1:0]  b_rd;
  logic [SEQ_W-1:0]  b_seq;

  logic [SEQ_W-1:0]  seq_q;
  logic              err_q;
  cause_e            cause_q;
  logic [SEQ_W-1:0]  err_seq_q;

  logic [1:0][IDX_W-1:0]  rf_ra;
  logic [1:0][DATA_W-1:0] rf_rd;
  logic [DATA_W-1:0] alu_res;
  logic              alu_legal;
  logic              opnd_ok, res_ok, pass, fail, accept, wd_fire, rf_we;

  assign rf_ra = {pkt_rs2_i, pkt_rs1_i};
  assign rf_we = pass && (b_rd != '0);

  chk_regfile #(.DATA_W(DATA_W), .NREG(NREG), .NRD(2)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (rf_we),
    .wa_i  (b_rd),
    .wd_i  (b_res),
    .ra_i  (rf_ra),
    .rd_o  (rf_rd)
  );

  chk_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (b_op),
    .a_i    (b_ra),
    .b_i    (b_rb),
    .res_o  (alu_res),
    .legal_o(alu_legal)
  );

  assign opnd_ok = (b_opa == b_ra) && (b_opb == b_rb);
  assign res_ok  = alu_legal && (alu_res == b_res);
  assign pass    = b_v && opnd_ok && res_ok;
  assign fail    = b_v && !(opnd_ok && res_ok);
  // packet in flight behind a failing one is squashed
  assign accept  = pkt_valid_i && !err_q && !fail;

  chk_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept || err_q),
    .fire_o(wd_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_v   <= 1'b0;
      b_op  <= '0;
      b_opa <= '0;
      b_opb <= '0;
      b_ra  <= '0;
      b_rb  <= '0;
      b_res <= '0;
      b_rd  <= '0;
      b_seq <= '0;
    end else begin
      b_v <= accept;
      if (accept) begin
        b_op  <= pkt_op_i;
        b_opa <= pkt_opa_i;
        b_opb <= pkt_opb_i;
        b_ra  <= rf_rd[0];
        b_rb  <= rf_rd[1];
        b_res <= pkt_res_i;
        b_rd  <= pkt_rd_i;
        b_seq <= seq_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seq_q <= '0;
    else if (fail)    seq_q <= b_seq;
    else if (accept)  seq_q <= seq_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q     <= 1'b0;
      cause_q   <= CAUSE_NONE;
      err_seq_q <= '0;
    end else if (fail) begin
      err_q     <= 1'b1;
      cause_q   <= opnd_ok ? CAUSE_RES : CAUSE_OPND;
      err_seq_q <= b_seq;
    end else if (wd_fire) begin
      err_q     <= 1'b1;
      cause_q   <= CAUSE_TMO;
      err_seq_q <= seq_q;
    end else if (err_q && restart_i) begin
      err_q     <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end
  end

  assign commit_o      = pass;
  assign commit_rd_o   = b_rd;
  assign commit_data_o = b_res;
  assign commit_seq_o  = b_seq;
  assign err_o         = err_q;
  assign err_cause_o   = cause_q;
  assign err_seq_o     = err_seq_q;

  assert_no_commit_in_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !commit_o);
  assert_err_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !restart_i) |=> (err_q && $stable(err_seq_q) && $stable(cause_q)));
  assert_err_has_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (cause_q != CAUSE_NONE));
  assert_commit_clean_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !err_q);
  assert_restart_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && restart_i) |=> !err_q);
endmodule

// File: tb/sim_commit_checker.sv
module sim_commit_checker;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        v = 1'b0, restart = 1'b0;
  logic [2:0]  op = '0;
  logic [3:0]  rs1 = '0, rs2 = '0, rd = '0;
  logic [31:0] opa = '0, opb = '0, res = '0;

  logic        commit_o, err_o;
  logic [3:0]  commit_rd_o;
  logic [31:0] commit_data_o;
  logic [7:0]  commit_seq_o, err_seq_o;
  logic [1:0]  err_cause_o;

  commit_checker #(.TIMEOUT_CYC(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pkt_valid_i(v), .pkt_op_i(op),
    .pkt_rs1_i(rs1), .pkt_rs2_i(rs2), .pkt_opa_i(opa), .pkt_opb_i(opb),
    .pkt_rd_i(rd), .pkt_res_i(res), .restart_i(restart),
    .commit_o(commit_o), .commit_rd_o(commit_rd_o), .commit_data_o(commit_data_o),
    .commit_seq_o(commit_seq_o), .err_o(err_o), .err_cause_o(err_cause_o),
    .err_seq_o(err_seq_o));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [32:0] ref_alu(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    case (o)
      3'd0: return {1'b1, a + b};
      3'd1: return {1'b1, a - b};
      3'd2: return {1'b1, a & b};
      3'd3: return {1'b1, a | b};
      3'd4: return {1'b1, a ^ b};
      3'd5: return {1'b1, 31'd0, ($signed(a) < $signed(b))};
      default: return 33'd0;
    endcase
  endfunction

  // reference model
  logic [31:0] m_rf [16];
  logic [31:0] g_rf [16];
  bit          p_v;
  logic [2:0]  p_op;
  logic [3:0]  p_rs1, p_rs2, p_rd;
  logic [31:0] p_opa, p_opb, p_res;
  int          p_seq, m_seq, m_eseq, m_idle;
  bit          m_err;
  int          m_cause;

  function automatic int eval_pend();  // 0 pass, 1 operand, 2 result
    logic [31:0] a, b;
    logic [32:0] r;
    a = (p_rs1 == 0) ? 32'd0 : m_rf[p_rs1];
    b = (p_rs2 == 0) ? 32'd0 : m_rf[p_rs2];
    if (a != p_opa || b != p_opb) return 1;
    r = ref_alu(p_op, a, b);
    if (!r[32] || r[31:0] != p_res) return 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_rf[i] = i;
      p_v = 0; m_seq = 0; m_eseq = 0; m_idle = 0; m_err = 0; m_cause = 0; p_seq = 0;
    end else begin
      int  ev;
      bit  failn, acc, fire, errp;
      ev = p_v ? eval_pend() : 0;
      failn = p_v && ev != 0;
      if (p_v && ev == 0 && p_rd != 0) m_rf[p_rd] = p_res;
      errp = m_err;
      acc = v && !errp && !failn;
      fire = !errp && !acc && (m_idle == TMO - 1);
      if (errp || acc || fire) m_idle = 0; else m_idle++;
      if (failn) begin
        m_err = 1; m_cause = ev; m_eseq = p_seq;
      end else if (fire) begin
        m_err = 1; m_cause = 3; m_eseq = m_seq;
      end else if (errp && restart) begin
        m_err = 0; m_cause = 0;
      end
      p_v = acc;
      if (acc) begin
        p_op = op; p_rs1 = rs1; p_rs2 = rs2; p_rd = rd;
        p_opa = opa; p_opb = opb; p_res = res; p_seq = m_seq;
      end
      if (failn) m_seq = p_seq;
      else if (acc) m_seq = (m_seq + 1) % 256;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit ec;
      ec = p_v && (eval_pend() == 0);
      chk("R4 commit_o", 32'(commit_o), 32'(ec));
      if (ec) begin
        chk("R4 commit_rd_o", 32'(commit_rd_o), 32'(p_rd));
        chk("R4 commit_data_o", commit_data_o, p_res);
        chk("R1 commit_seq_o", 32'(commit_seq_o), 32'(p_seq));
      end
      chk("R6 err_o", 32'(err_o), 32'(m_err));
      if (m_err) begin
        chk("R6 err_cause_o", 32'(err_cause_o), 32'(m_cause));
        chk("R6 err_seq_o", 32'(err_seq_o), 32'(m_eseq));
      end
    end
  end

  // stimulus
  int nseq = 0;

  task automatic send(input logic [2:0] o, input logic [3:0] d, input logic [3:0] s1,
                      input logic [3:0] s2, input bit ca, input bit cr, input bit upd);
    logic [32:0] r;
    @(posedge clk); #2;
    r = ref_alu(o, g_rf[s1], g_rf[s2]);
    v = 1; op = o; rd = d; rs1 = s1; rs2 = s2;
    opa = g_rf[s1] ^ (ca ? 32'h1 : 32'h0);
    opb = g_rf[s2];
    res = r[31:0] ^ (cr ? 32'h80 : 32'h0);
    if (upd) begin
      if (d != 0) g_rf[d] = r[31:0];
      nseq = (nseq + 1) % 256;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; v = 0;
    end
  endtask

  task automatic do_restart();
    @(posedge clk); #2; v = 0; restart = 1;
    @(posedge clk); #2; restart = 0;
    for (int i = 0; i < 16; i++) g_rf[i] = m_rf[i];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) g_rf[i] = i;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R4 reset commit_o", 32'(commit_o), 0);
    chk("R6 reset err_o", 32'(err_o), 0);

    // R5: reset image, register k holds k
    send(3'd0, 4'd11, 4'd12, 4'd13, 0, 0, 1);
    idle(1); @(negedge clk);
    chk("R5 reset values 12+13", commit_data_o, 32'd25);
    chk("R1 first seq", 32'(commit_seq_o), 0);

    // R9: back-to-back dependent chain
    send(3'd0, 4'd1, 4'd2, 4'd3, 0, 0, 1);
    send(3'd1, 4'd4, 4'd1, 4'd5, 0, 0, 1);
    send(3'd4, 4'd1, 4'd4, 4'd1, 0, 0, 1);
    send(3'd3, 4'd2, 4'd1, 4'd1, 0, 0, 1);
    idle(3); @(negedge clk);
    chk("R9 forwarded chain no error", 32'(err_o), 0);

    // R3: remaining ops, signed SLT
    send(3'd1, 4'd7, 4'd0, 4'd3, 0, 0, 1);   // r7 = -3
    send(3'd5, 4'd8, 4'd7, 4'd6, 0, 0, 1);   // -3 < 6
    idle(1); @(negedge clk);
    chk("R3 SLT negative less", commit_data_o, 32'd1);
    send(3'd5, 4'd9, 4'd6, 4'd7, 0, 0, 1);
    idle(1); @(negedge clk);
    chk("R3 SLT positive not less", commit_data_o, 32'd0);
    send(3'd2, 4'd10, 4'd7, 4'd14, 0, 0, 1);
    send(3'd3, 4'd12, 4'd7, 4'd15, 0, 0, 1);
    idle(2);

    // R5: write to r0 discarded
    send(3'd0, 4'd0, 4'd5, 4'd6, 0, 0, 1);
    send(3'd0, 4'd13, 4'd0, 4'd5, 0, 0, 1);
    idle(3); @(negedge clk);
    chk("R5 r0 still zero", 32'(err_o), 0);

    // R2 + R6: operand mismatch, trailing packet dropped
    send(3'd0, 4'd3, 4'd4, 4'd5, 1, 0, 0);
    send(3'd0, 4'd3, 4'd6, 4'd5, 0, 0, 0);
    idle(3); @(negedge clk);
    chk("R2 err_o", 32'(err_o), 1);
    chk("R2 cause operand", 32'(err_cause_o), 32'h1);
    chk("R6 err_seq faulting", 32'(err_seq_o), 32'(nseq));
    send(3'd0, 4'd3, 4'd4, 4'd5, 0, 0, 0);
    send(3'd1, 4'd6, 4'd4, 4'd5, 0, 0, 0);
    idle(2); @(negedge clk);
    chk("R6 dropped keeps err_seq", 32'(err_seq_o), 32'(nseq));
    chk("R6 dropped keeps cause", 32'(err_cause_o), 32'h1);
    do_restart();
    @(negedge clk);
    chk("R7 err cleared", 32'(err_o), 0);
    send(3'd0, 4'd3, 4'd4, 4'd5, 0, 0, 1);
    idle(1); @(negedge clk);
    chk("R7 replay seq", 32'(commit_seq_o), 32'((nseq + 255) % 256));

    // R3: result mismatch
    send(3'd4, 4'd6, 4'd3, 4'd2, 0, 1, 0);
    idle(3); @(negedge clk);
    chk("R3 cause result", 32'(err_cause_o), 32'h2);
    do_restart();

    // R3: illegal opcode
    send(3'd6, 4'd6, 4'd3, 4'd2, 0, 0, 0);
    idle(3); @(negedge clk);
    chk("R3 illegal op cause", 32'(err_cause_o), 32'h2);
    do_restart();

    // R2: both wrong, operand wins
    send(3'd0, 4'd6, 4'd3, 4'd2, 1, 1, 0);
    idle(3); @(negedge clk);
    chk("R2 operand priority", 32'(err_cause_o), 32'h1);
    do_restart();

    // R8: reload, then timeout
    idle(TMO - 3);
    send(3'd0, 4'd6, 4'd3, 4'd2, 0, 0, 1);
    idle(TMO - 3); @(negedge clk);
    chk("R8 reload no timeout", 32'(err_o), 0);
    idle(5); @(negedge clk);
    chk("R8 timeout err_o", 32'(err_o), 1);
    chk("R8 timeout cause", 32'(err_cause_o), 32'h3);
    chk("R8 timeout seq", 32'(err_seq_o), 32'(nseq));
    do_restart();
    send(3'd0, 4'd6, 4'd3, 4'd2, 0, 0, 1);
    idle(1); @(negedge clk);
    chk("R7 seq after timeout", 32'(commit_seq_o), 32'((nseq + 255) % 256));
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule